// File: doc/BRIEF.md
# Two-Wire Idle-Delimited Serial Word Receiver

This receiver listens to a pair of lines, P and N, on which a sender encodes each bit as a shared phase with both lines low, followed by one line going high. If N goes high while P stays low, the bit is 0. If P goes high while N stays low, the bit is 1. Both lines held high for long enough mean the bus is idle. Bits within a transaction follow one another with no idle between them, and every transaction closes with an idle period.

Both lines are resynchronized before any decoding. The receiver collects the recovered bits into words, placing the earliest bit in the lowest position. It presents each complete word with a one-cycle valid pulse. It signals the close of a transaction with a one-cycle strobe, and it reports two kinds of error: protocol violations on the lines, and transactions that end partway through a word.

The idle time is counted in clock samples through the parameter `IDLE_CYCLES`, which should be at least 2. Choose it so that the both-high time between bits inside a transaction is always shorter than the idle time.

Top module: `tw_rx`

## Requirements
- R1: Each line passes through two synchronizing flip-flops, and the decode logic then registers its outputs. An input change therefore reaches the outputs at the third rising clock edge after it is first sampled.
- R2: The bit value is fixed at the sample in which one line rises out of the both-low phase. P=0 with N=1 decodes a 0, and P=1 with N=0 decodes a 1.
- R3: Bits are packed into words of `WORD_BITS` (default 32) bits, with the first received bit in bit 0. When a word is complete, `word_vld_o` pulses for exactly one cycle. `word_o` changes only in that cycle and holds its value until the next complete word.
- R4: Several words can be received back to back in one transaction. A both-high gap shorter than `IDLE_CYCLES` samples between two bits does not end the transaction.
- R5: `eot_o` pulses once, on the sample that completes `IDLE_CYCLES` consecutive both-high samples. It pulses only if at least one both-low phase began since the previous idle.
- R6: A transaction that goes idle with a bit count that is not a multiple of `WORD_BITS` discards the partial bits. `frag_err_o` pulses in the same cycle as `eot_o`, no word is emitted, and `word_o` is unchanged.
- R7: If both lines rise together while a bit is expected, `proto_err_o` pulses for one cycle. The partial word is discarded and the rest of the transaction is ignored until the next idle. The next transaction starts from an empty word.
- R8: `proto_err_o` also pulses in two other cases: a single line falls while the bus is at rest with both lines high, or the high line swaps directly to the other line without a both-low phase. In both cases the receiver then waits for idle.
- R9: After reset all outputs are 0. No bit is accepted until the lines have first been seen idle for `IDLE_CYCLES` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_p_i | input | 1 | P line of the bus, asynchronous |
| line_n_i | input | 1 | N line of the bus, asynchronous |
| word_o | output | WORD_BITS | Last complete word, first bit in bit 0 |
| word_vld_o | output | 1 | One-cycle pulse when `word_o` takes a new word |
| eot_o | output | 1 | One-cycle pulse when a transaction ends in idle |
| proto_err_o | output | 1 | One-cycle pulse on a line-level protocol violation |
| frag_err_o | output | 1 | One-cycle pulse when a partial word is dropped at idle |

## Verification
The checker watches, on every cycle, the rules that hold at any instant:
- the word valid, end and protocol-error signals are single-cycle pulses;
- the word output is stable outside a valid pulse;
- a fragment error always coincides with an end strobe and never with a valid word;
- an end strobe is always preceded, three samples earlier, by both lines high.

Only the bench's scenarios can show the rest:
- that bit values and their order are recovered correctly;
- that a short high gap does not split a transaction;
- that the receiver ignores the lines until the first idle;
- that it recovers with an empty word after each kind of protocol error.

The bench compares a behavioural model against the outputs every cycle, and it also tallies per-scenario event counts.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

  // Line decoder states.
  typedef enum logic [1:0] {
    DEC_WAIT  = 2'd0,  // ignoring the lines until an idle is seen
    DEC_READY = 2'd1,  // both lines high, bus at rest or between bits
    DEC_LOW   = 2'd2,  // both lines low, a bit is expected
    DEC_HOLD  = 2'd3   // one line high, bit already committed
  } dec_state_t;

endpackage

// File: rtl/tw_rx_sync.sv
module tw_rx_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        stage_q[g] <= RST_VAL;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/tw_rx_idle_timer.sv
module tw_rx_idle_timer #(
  parameter int IDLE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic both_hi_i,
  output logic idle_hit_o
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] HIT_AT  = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (both_hi_i) begin
      if (cnt_q == CNT_SAT) begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // One sample completes the run of high samples: fires once per idle.
  assign idle_hit_o = both_hi_i && (cnt_q == HIT_AT);

endmodule

// File: rtl/tw_rx_line_fsm.sv
module tw_rx_line_fsm
  import tw_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic line_p_i,
  input  logic line_n_i,
  input  logic idle_hit_i,
  output logic bit_stb_o,
  output logic bit_val_o,
  output logic perr_o,
  output logic eot_o
);

  dec_state_t st_q, st_d;
  logic       held_q, held_d;
  logic       active_q, active_d;

  logic both_lo, both_hi, one_hi;

  assign both_lo = !line_p_i && !line_n_i;
  assign both_hi =  line_p_i &&  line_n_i;
  assign one_hi  =  line_p_i ^   line_n_i;

  always_comb begin
    st_d      = st_q;
    held_d    = held_q;
    active_d  = active_q;
    bit_stb_o = 1'b0;
    bit_val_o = line_p_i;
    perr_o    = 1'b0;

    unique case (st_q)
      DEC_WAIT: begin
        if (idle_hit_i) st_d = DEC_READY;
      end
      DEC_READY: begin
        if (both_lo) begin
          st_d     = DEC_LOW;
          active_d = 1'b1;
        end else if (one_hi) begin
          perr_o = 1'b1;
          st_d   = DEC_WAIT;
        end
      end
      DEC_LOW: begin
        if (one_hi) begin
          bit_stb_o = 1'b1;
          held_d    = line_p_i;
          st_d      = DEC_HOLD;
        end else if (both_hi) begin
          perr_o = 1'b1;
          st_d   = DEC_WAIT;
        end
      end
      DEC_HOLD: begin
        if (both_lo) begin
          st_d = DEC_LOW;
        end else if (both_hi) begin
          st_d = DEC_READY;
        end else if (line_p_i != held_q) begin
          perr_o = 1'b1;
          st_d   = DEC_WAIT;
        end
      end
      default: st_d = DEC_WAIT;
    endcase

    eot_o = idle_hit_i && active_q;
    if (idle_hit_i) active_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q     <= DEC_WAIT;
      held_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      held_q   <= held_d;
      active_q <= active_d;
    end
  end

endmodule

// File: rtl/tw_rx_packer.sv
module tw_rx_packer #(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 bit_stb_i,
  input  logic                 bit_val_i,
  input  logic                 flush_i,
  input  logic                 idle_hit_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_vld_o,
  output logic                 frag_err_o
);

  localparam int BCW = $clog2(WORD_BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_BITS - 1);

  logic [WORD_BITS-2:0] sh_q, sh_d;
  logic [BCW-1:0]       cnt_q, cnt_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 vld_d, ferr_d;
  logic                 sh_en, word_en;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = {bit_val_i, sh_q[WORD_BITS-2:1]};
    sh_en   = 1'b0;
    word_d  = {bit_val_i, sh_q};
    word_en = 1'b0;
    vld_d   = 1'b0;
    ferr_d  = 1'b0;

    if (flush_i) begin
      cnt_d = '0;
    end else if (bit_stb_i) begin
      sh_en = 1'b1;
      if (cnt_q == LAST_BIT) begin
        word_en = 1'b1;
        vld_d   = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (idle_hit_i) begin
      ferr_d = (cnt_q != '0);
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
      frag_err_o <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      word_vld_o <= vld_d;
      frag_err_o <= ferr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/tw_rx.sv
module tw_rx #(
  parameter int WORD_BITS   = 32,
  parameter int IDLE_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 line_p_i,
  input  logic                 line_n_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_vld_o,
  output logic                 eot_o,
  output logic                 proto_err_o,
  output logic                 frag_err_o
);

  logic       core_rst_n;
  logic [1:0] lines_s;
  logic       idle_hit;
  logic       bit_stb, bit_val, perr, eot;
  logic       eot_q, perr_q;

  // Reset: asserted asynchronously, released on the clock.
  tw_rx_sync #(
    .STAGES (2),
    .WIDTH  (1),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .d_i    (1'b1),
    .q_o    (core_rst_n)
  );

  // Lines resynchronized; reset value is the idle level.
  tw_rx_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (2),
    .RST_VAL(2'b11)
  ) u_line_sync (
    .clk_i  (clk_i),
    .rst_n_i(core_rst_n),
    .d_i    ({line_p_i, line_n_i}),
    .q_o    (lines_s)
  );

  tw_rx_idle_timer #(
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_idle (
    .clk_i     (clk_i),
    .rst_n_i   (core_rst_n),
    .both_hi_i (lines_s[1] && lines_s[0]),
    .idle_hit_o(idle_hit)
  );

  tw_rx_line_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_n_i   (core_rst_n),
    .line_p_i  (lines_s[1]),
    .line_n_i  (lines_s[0]),
    .idle_hit_i(idle_hit),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .perr_o    (perr),
    .eot_o     (eot)
  );

  tw_rx_packer #(
    .WORD_BITS(WORD_BITS)
  ) u_pack (
    .clk_i     (clk_i),
    .rst_n_i   (core_rst_n),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .flush_i   (perr),
    .idle_hit_i(idle_hit),
    .word_o    (word_o),
    .word_vld_o(word_vld_o),
    .frag_err_o(frag_err_o)
  );

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      eot_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      eot_q  <= eot;
      perr_q <= perr;
    end
  end

  assign eot_o       = eot_q;
  assign proto_err_o = perr_q;

endmodule

// File: rtl/tw_rx_chk.sv
module tw_rx_chk #(
  parameter int WORD_BITS = 32
) (
  input logic                 clk_i,
  input logic                 rst_n_i,
  input logic                 line_p_i,
  input logic                 line_n_i,
  input logic [WORD_BITS-1:0] word_o,
  input logic                 word_vld_o,
  input logic                 eot_o,
  input logic                 proto_err_o,
  input logic                 frag_err_o
);

  // R3: a word takes at least two samples per bit, so valid never repeats
  p_word_vld_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    word_vld_o |=> !word_vld_o);

  // R3: the word output moves only together with its valid pulse
  p_word_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !word_vld_o |-> $stable(word_o));

  // R5: the end strobe is a single pulse
  p_eot_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    eot_o |=> !eot_o);

  // R5 and R1: an end strobe follows a both-high sample three edges earlier
  p_eot_after_high_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    eot_o |-> ($past(line_p_i, 3) && $past(line_n_i, 3)));

  // R6: a dropped fragment is always reported at the end of a transaction
  p_frag_with_eot_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frag_err_o |-> eot_o);

  // R6: a dropped fragment never appears as a word
  p_frag_not_word_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frag_err_o |-> !word_vld_o);

  // R7: after a protocol error the receiver waits, so no second error follows at once
  p_perr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    proto_err_o |=> !proto_err_o);

endmodule

bind tw_rx tw_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .line_p_i   (line_p_i),
  .line_n_i   (line_n_i),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .eot_o      (eot_o),
  .proto_err_o(proto_err_o),
  .frag_err_o (frag_err_o)
);

// File: tb/tw_rx_tb_top.sv
module tw_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int IDLE       = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         lp, ln;
  logic [W-1:0] word;
  logic         vld, eot, perr, ferr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_rx #(.WORD_BITS(W), .IDLE_CYCLES(IDLE)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .line_p_i(lp), .line_n_i(ln),
    .word_o(word), .word_vld_o(vld), .eot_o(eot),
    .proto_err_o(perr), .frag_err_o(ferr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int           m_rel;
  int           m_d1p, m_d1n, m_d2p, m_d2n;
  int           m_mode;   // 0 wait, 1 rest, 2 low, 3 one high
  int           m_run;
  int           m_active;
  int           m_held;
  bit           m_bits[$];
  logic [W-1:0] e_word;
  bit           e_vld, e_eot, e_perr, e_ferr;

  task automatic model_step(input int p, input int n);
    bit hit;
    int bv;
    hit = (p == 1 && n == 1 && m_run == IDLE - 1);
    if (p == 1 && n == 1) begin
      if (m_run < IDLE) m_run++;
    end else m_run = 0;
    bv = -1;
    if (m_mode == 0) begin
      if (hit) m_mode = 1;
    end else if (m_mode == 1) begin
      if (p == 0 && n == 0) begin m_mode = 2; m_active = 1; end
      else if (p != n) begin e_perr = 1; m_mode = 0; end
    end else if (m_mode == 2) begin
      if (p != n) begin bv = p; m_held = p; m_mode = 3; end
      else if (p == 1) begin e_perr = 1; m_mode = 0; end
    end else begin
      if (p == 0 && n == 0) m_mode = 2;
      else if (p == 1 && n == 1) m_mode = 1;
      else if (p != m_held) begin e_perr = 1; m_mode = 0; end
    end
    if (hit) begin
      e_eot = (m_active != 0);
      m_active = 0;
    end
    if (e_perr) m_bits.delete();
    else if (bv >= 0) begin
      m_bits.push_back(bv[0]);
      if (m_bits.size() == W) begin
        for (int i = 0; i < W; i++) e_word[i] = m_bits[i];
        e_vld = 1;
        m_bits.delete();
      end
    end else if (hit) begin
      e_ferr = (m_bits.size() != 0);
      m_bits.delete();
    end
  endtask

  always @(posedge clk) begin
    e_vld = 0; e_eot = 0; e_perr = 0; e_ferr = 0;
    if (!rst_n || m_rel < 2) begin
      if (rst_n) m_rel++; else m_rel = 0;
      m_d1p = 1; m_d1n = 1; m_d2p = 1; m_d2n = 1;
      m_mode = 0; m_run = 0; m_active = 0; m_held = 0;
      m_bits.delete();
      e_word = '0;
    end else begin
      model_step(m_d2p, m_d2n);
      m_d2p = m_d1p; m_d2n = m_d1n;
      m_d1p = int'(lp); m_d1n = int'(ln);
    end
  end

  // ---------------- per-cycle comparison and event tally ----------------
  int n_words, n_eot, n_perr, n_ferr;
  logic [W-1:0] got[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(vld == e_vld,   "R1 R3 valid timing", vld, e_vld);
      check(word == e_word, "R2 R3 word value", word, e_word);
      check(eot == e_eot,   "R5 end strobe", eot, e_eot);
      check(perr == e_perr, "R7 R8 protocol error", perr, e_perr);
      check(ferr == e_ferr, "R6 fragment error", ferr, e_ferr);
      if (vld) begin n_words++; got.push_back(word); end
      if (eot) n_eot++;
      if (perr) n_perr++;
      if (ferr) n_ferr++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit p, input bit n, input int cyc);
    lp = p; ln = n;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    drive(1'b0, 1'b0, 3);
    drive(b, !b, 3);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) send_bit(w[i]);
  endtask

  task automatic go_idle();
    drive(1'b1, 1'b1, IDLE + 4);
  endtask

  task automatic clear_tally();
    @(posedge clk); #(CLK_PERIOD/4);
    n_words = 0; n_eot = 0; n_perr = 0; n_ferr = 0;
    got.delete();
    @(negedge clk);
  endtask

  task automatic expect_tally(input string req, input int w, input int e, input int pe, input int fe);
    @(posedge clk); #(CLK_PERIOD/4);
    check(n_words == w, {req, " word count"}, n_words, w);
    check(n_eot == e,   {req, " end count"}, n_eot, e);
    check(n_perr == pe, {req, " protocol error count"}, n_perr, pe);
    check(n_ferr == fe, {req, " fragment count"}, n_ferr, fe);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; lp = 1'b0; ln = 1'b0;
    n_words = 0; n_eot = 0; n_perr = 0; n_ferr = 0;
    repeat (4) @(negedge clk);
    // R9: outputs cleared during reset
    check({vld, eot, perr, ferr} == 4'b0, "R9 reset pulses", {vld, eot, perr, ferr}, 0);
    check(word == '0, "R9 reset word", word, 0);
    rst_n = 1'b1;

    // R9: bits before the first idle are ignored
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    go_idle();
    expect_tally("R9", 0, 0, 0, 0);

    // R2 R3 R5: one word, mixed bits
    clear_tally();
    send_word(32'hCA5A_3C96);
    go_idle();
    expect_tally("R5", 1, 1, 0, 0);
    check(got.size() == 1 && got[0] == 32'hCA5A_3C96, "R2 R3 word LSB first",
          got.size() ? got[0] : 0, 32'hCA5A_3C96);

    // R4: two words with a short high gap inside the transaction
    clear_tally();
    send_word(32'h0000_0000);
    drive(1'b1, 1'b1, IDLE - 3);
    send_word(32'hFFFF_FFFF);
    go_idle();
    expect_tally("R4", 2, 1, 0, 0);
    check(got.size() == 2 && got[1] == 32'hFFFF_FFFF, "R4 second word",
          got.size() == 2 ? got[1] : 0, 32'hFFFF_FFFF);

    // R6: partial word dropped at idle
    clear_tally();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    go_idle();
    expect_tally("R6", 0, 1, 0, 1);
    check(word == 32'hFFFF_FFFF, "R6 word unchanged", word, 32'hFFFF_FFFF);

    // R7: both lines rise while a bit is expected
    clear_tally();
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    drive(1'b0, 1'b0, 3);
    go_idle();
    expect_tally("R7", 0, 1, 1, 0);
    clear_tally();
    send_word(32'h1234_5678);
    go_idle();
    expect_tally("R7 recovery", 1, 1, 0, 0);
    check(word == 32'h1234_5678, "R7 empty word after error", word, 32'h1234_5678);

    // R8: direct swap of the high line
    clear_tally();
    drive(1'b0, 1'b0, 3); drive(1'b0, 1'b1, 3); drive(1'b1, 1'b0, 3);
    go_idle();
    expect_tally("R8 swap", 0, 1, 1, 0);

    // R8: single line falls from rest
    clear_tally();
    drive(1'b0, 1'b1, 3);
    go_idle();
    expect_tally("R8 drop", 0, 0, 1, 0);
    clear_tally();
    send_word(32'h8000_0001);
    go_idle();
    expect_tally("R8 recovery", 1, 1, 0, 0);
    check(word == 32'h8000_0001, "R8 word after recovery", word, 32'h8000_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule